// File: doc/BRIEF.md
# DSD Stuck-Polarity Guard

This block sits in the path of a one-bit DSD audio stream. It takes one bit for every cycle in which the bit strobe is high. It looks at the latest 28 bits and checks whether one polarity has taken over. A stream in which nearly every bit is a one, or nearly every bit is a zero, carries a large DC component and would push the analog output toward a rail. When the guard finds such a stream, it raises an invalid flag. For as long as the flag stays up, it sends a neutral alternating 0101 pattern downstream in place of the input bits.

Detection is switched on by a configuration input, and the guard is off at reset. While it is off, bits pass through untouched and no flag can rise. A second configuration input lets the invalid condition drive a mute output as well. The window is a shift register with a running count of ones. Each strobe adds the arriving bit to the count and subtracts the departing bit, so no adder tree is needed. The guard makes no judgement until a full window has arrived since reset or since the detector was enabled.

Top module: `dsd_dc_guard`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the window, the count, the invalid flag and the mute output, and the data passes straight through afterwards.
- R2: While det_en is 0, dsd_out equals dsd_in and invalid and mute stay 0. Taking det_en low also discards the window contents.
- R3: With det_en at 1 and a full window, invalid is 1 after the strobe edge when 25 or more of the latest 28 bits are ones.
- R4: With det_en at 1 and a full window, invalid is 1 after the strobe edge when 3 or fewer of the latest 28 bits are ones, which means 25 or more are zeros.
- R5: A full window holding from 4 to 24 ones, inclusive, leaves invalid at 0.
- R6: No invalid decision is made until 28 strobes have been taken since reset or since det_en last rose. After 27 bits of a single value, invalid is still 0, and it goes to 1 on the 28th.
- R7: While invalid is 1, dsd_out ignores dsd_in and toggles once on each strobe, giving an alternating 0/1 pattern.
- R8: mute is registered as invalid AND mute_en at each strobe. With mute_en at 0, mute stays 0 even while invalid is 1.
- R9: Pass-through resumes on the first strobe after which the window count lies inside 4 to 24 again, with no hold-off.
- R10: While det_en is 1, invalid and mute change only at an edge where bit_strobe is high. A change on mute_en or dsd_in without a strobe leaves them as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | Qualifies dsd_in as a new stream bit |
| dsd_in | input | 1 | Incoming DSD bit |
| det_en | input | 1 | Enables invalid-pattern detection |
| mute_en | input | 1 | Allows detection to drive mute |
| dsd_out | output | 1 | Bit passed downstream, or the idle pattern while invalid |
| invalid | output | 1 | Registered invalid-stream flag |
| mute | output | 1 | Registered mute indication |

## Verification
The hardest states to reach are the exact threshold edges, with 24 against 25 ones and 3 against 4 ones. The stimulus reaches them by shifting in a complete 28-bit word, which leaves the window fully determined whatever came before. A table of such words steps across both boundaries, and the bench checks invalid and mute for each word. The other hard cases are recovery and the idle pattern. For these, directed sequences start from an all-zero window and feed ones one at a time, so the count crosses back into the valid range on a known strobe.

// File: rtl/dsd_dc_guard.sv
module dsd_dc_guard #(
  parameter int WIN = 28,
  parameter int THR = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_stb,
  input  logic dsd_in,
  input  logic det_en,
  input  logic mute_en,
  output logic dsd_out,
  output logic invalid,
  output logic mute
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] HI_LIM = CW'(THR);
  localparam logic [CW-1:0] LO_LIM = CW'(WIN - THR);
  localparam logic [CW-1:0] FULL   = CW'(WIN);

  logic [WIN-1:0] win;
  logic [CW-1:0]  ones, fill;
  logic           idle_ph;

  wire [WIN-1:0] win_nxt  = {win[WIN-2:0], dsd_in};
  wire [CW-1:0]  ones_nxt = ones + CW'(dsd_in) - CW'(win[WIN-1]);
  wire [CW-1:0]  fill_nxt = (fill == FULL) ? fill : fill + 1'b1;
  wire           bad_nxt  = (fill_nxt == FULL) && (ones_nxt > HI_LIM || ones_nxt < LO_LIM);

  always_ff @(posedge clk) begin
    if (rst || !det_en) begin
      win     <= '0;
      ones    <= '0;
      fill    <= '0;
      invalid <= 1'b0;
      mute    <= 1'b0;
    end else if (bit_stb) begin
      win     <= win_nxt;
      ones    <= ones_nxt;
      fill    <= fill_nxt;
      invalid <= bad_nxt;
      mute    <= bad_nxt & mute_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          idle_ph <= 1'b0;
    else if (bit_stb) idle_ph <= ~idle_ph;
  end

  assign dsd_out = invalid ? idle_ph : dsd_in;

  AST_MUTE_NEEDS_INVALID: assert property (@(posedge clk) disable iff (rst)
    mute |-> invalid); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> (!invalid && !mute)); // R2
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (rst)
    (!bit_stb && det_en) |=> ($stable(invalid) && $stable(mute))); // R10
  AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (invalid && bit_stb) |=> (!invalid || dsd_out != $past(dsd_out))); // R7
  AST_FULL_BEFORE_FLAG: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (fill == FULL)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ones <= fill); // R3
endmodule

// File: tb/sim_dsd_dc_guard.sv
module sim_dsd_dc_guard;
  logic clk = 1'b0, rst = 1'b1, bit_stb = 1'b0, dsd_in = 1'b0, det_en = 1'b0, mute_en = 1'b0;
  logic dsd_out, invalid, mute;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dsd_dc_guard u0 (.clk(clk), .rst(rst), .bit_stb(bit_stb), .dsd_in(dsd_in),
    .det_en(det_en), .mute_en(mute_en), .dsd_out(dsd_out), .invalid(invalid), .mute(mute));

  // {mute_en, expected invalid, 28-bit window, oldest bit first}
  localparam logic [29:0] VEC [8] = '{
    {1'b1, 1'b1, 28'h0000000},
    {1'b1, 1'b1, 28'hFFFFFFF},
    {1'b0, 1'b1, 28'hFFFFFF8},
    {1'b1, 1'b0, 28'hFFFFFF0},
    {1'b1, 1'b1, 28'h0000007},
    {1'b1, 1'b0, 28'h000000F},
    {1'b1, 1'b0, 28'hAAAAAAA},
    {1'b0, 1'b1, 28'h0000001}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk); dsd_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic o1, o2, o3;
    repeat (3) @(negedge clk);
    rst = 1'b0; dsd_in = 1'b1;
    @(negedge clk);
    chk(invalid == 0 && mute == 0, "R1 reset flags", {invalid, mute}, 0);
    chk(dsd_out == 1, "R1 pass-through after reset", dsd_out, 1);

    // R2: detector off, all-zero stream passes untouched
    for (int i = 0; i < 30; i++) send(1'b0);
    chk(invalid == 0 && mute == 0, "R2 disabled no flag", {invalid, mute}, 0);
    dsd_in = 1'b1; #1;
    chk(dsd_out == 1, "R2 disabled pass-through", dsd_out, 1);

    det_en = 1'b1;
    for (int v = 0; v < 8; v++) begin
      mute_en = VEC[v][29];
      for (int b = 27; b >= 0; b--) send(VEC[v][b]);
      chk(invalid == VEC[v][28], $sformatf("R3/R4/R5 vector %0d invalid", v), invalid, VEC[v][28]);
      chk(mute == (VEC[v][28] & VEC[v][29]), $sformatf("R8 vector %0d mute", v), mute,
          VEC[v][28] & VEC[v][29]);
    end

    // R6: re-arm after enable, 27 bits are not enough
    det_en = 1'b0; @(negedge clk); det_en = 1'b1; mute_en = 1'b1;
    for (int i = 0; i < 27; i++) send(1'b0);
    chk(invalid == 0, "R6 27 bits after enable", invalid, 0);
    send(1'b0);
    chk(invalid == 1, "R6 28th bit flags", invalid, 1);

    // R7: alternating idle pattern ignoring dsd_in
    o1 = dsd_out;
    send(1'b0); o2 = dsd_out;
    chk(o2 != o1 && invalid, "R7 idle toggles", o2, !o1);
    send(1'b1); o3 = dsd_out;
    chk(o3 != o2 && invalid, "R7 idle toggles ignoring input", o3, !o2);

    // R10: no strobe, no flag change
    for (int i = 0; i < 27; i++) send(1'b0);
    chk(mute == 1, "R10 mute set before hold", mute, 1);
    @(negedge clk); mute_en = 1'b0; dsd_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(mute == 1 && invalid == 1, "R10 flags held without strobe", {invalid, mute}, 3);
    send(1'b0);
    chk(mute == 0, "R8 mute drops on strobe with mute_en low", mute, 0);

    // R9: recovery from all-zero window
    for (int i = 0; i < 28; i++) send(1'b0);
    for (int i = 0; i < 3; i++) send(1'b1);
    chk(invalid == 1, "R9 three ones still invalid", invalid, 1);
    send(1'b1);
    chk(invalid == 0, "R9 fourth one resumes", invalid, 0);
    #1; chk(dsd_out == dsd_in, "R9 pass-through resumes", dsd_out, dsd_in);

    // R1: reset while invalid
    mute_en = 1'b1;
    for (int i = 0; i < 28; i++) send(1'b1);
    chk(invalid == 1 && mute == 1, "R3 all ones flags and mutes", {invalid, mute}, 3);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; dsd_in = 1'b0; #1;
    chk(invalid == 0 && mute == 0, "R1 reset clears flags", {invalid, mute}, 0);
    chk(dsd_out == 0, "R1 reset restores pass-through", dsd_out, 0);
    for (int i = 0; i < 27; i++) send(1'b1);
    chk(invalid == 0, "R1 window cleared by reset", invalid, 0);

    // R2: disabling clears the flag
    send(1'b1);
    chk(invalid == 1, "R2 flag before disable", invalid, 1);
    @(negedge clk); det_en = 1'b0; @(negedge clk);
    chk(invalid == 0 && mute == 0, "R2 disable clears flags", {invalid, mute}, 0);

    finish_run();
  end
endmodule